// File: doc/BRIEF.md
# PS/2 Host Transmitter with Idle Status

This block lets a host send one byte at a time to a PS/2 device over the two-wire clock/data bus. The host programs a small control register that holds a channel enable bit and a transmit-mode bit. It then writes a byte into the transmit register. The block carries out the host-to-device handshake. First it holds the clock line low to inhibit the device. Next it pulls data low as a request-to-send and releases the clock. It then presents one frame bit each time the device pulls the clock low.

Progress is reported through a transmitter-idle status bit. A write that starts a transfer clears this bit. It returns high in four cases: the frame completes on the eleventh device clock falling edge, the device times out, the host clears the transmit-mode bit, or the host clears the enable bit. A timeout also sets a sticky timeout flag. Whenever the idle bit rises, the block emits a one-cycle interrupt pulse. The block drives both lines in open-drain style: an output of 1 means "pull the line low", and an output of 0 means "release the line".

The register map has three addresses. Address 0 is control: bit 0 is enable and bit 1 is transmit mode, and both read back. Address 1 is the transmit byte, which is write-only and reads as 0. Address 2 is status: bit 0 is idle and bit 1 is the timeout flag. Writing 1 to status bit 1 clears the timeout flag. All timing windows are parameters counted in system clock cycles.

Top module: `ps2_host_tx`

## Requirements
- R1: A write to address 1 while idle=1, enable=1 and mode=1 clears status bit 0 (idle) on the clock edge that captures the write.
- R2: After an accepted write, the clock line is pulled low (kbd_clk_oe=1) with data released (kbd_dat_oe=0) for at least INHIBIT_CYC cycles. The block then pulls data low (start bit, kbd_dat_oe=1) and releases the clock.
- R3: On device clock falling edges 1 to 10, the block presents the 8 data bits least significant first, then an odd parity bit, then a released line for the stop bit. A bit value b is shown as kbd_dat_oe = not b.
- R4: On the 11th device clock falling edge, idle returns to 1 and both lines are released.
- R5: If no device clock falling edge arrives within START_TMO_CYC cycles of the request-to-send, idle returns to 1, the timeout flag (status bit 1) is set, and both lines are released.
- R6: If the 11th falling edge has not arrived within FRAME_TMO_CYC cycles of the first falling edge, idle returns to 1 and the timeout flag is set.
- R7: A control write with bit 1 (mode) equal to 0 ends any transfer in progress on the next edge: idle becomes 1 and both lines are released.
- R8: A control write with bit 0 (enable) equal to 0 aborts any transfer in progress on the next edge: idle becomes 1 and both lines are released.
- R9: irq is a one-cycle pulse on the same edge where idle goes from 0 to 1, and on no other edge.
- R10: A write to address 1 is ignored while idle=0, while enable=0, or while mode=0. Such a write starts no transfer and does not change the byte being sent.
- R11: Writing 1 to status bit 1 clears the timeout flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| kbd_clk_in | input | 1 | Sensed level of the PS/2 clock line |
| kbd_clk_oe | output | 1 | 1 pulls the PS/2 clock line low |
| kbd_dat_oe | output | 1 | 1 pulls the PS/2 data line low |
| irq | output | 1 | One-cycle pulse when idle rises |

## Verification
Register writes act on the edge that captures them. Idle, the timeout flag, the line drivers and irq can therefore all be read on the falling clock edge right after the write strobe, and irq appears on that same edge as the idle rise. A device clock fall reaches the FSM three edges after the line drops: two synchroniser stages, then the state register. The bench therefore samples the data driver five cycles into each low phase of the device clock, well before the line rises again. Timeouts are checked on both sides of their windows: some cycles before the limit, idle must still be 0, and some cycles after it, idle and the timeout flag must both be 1.

// File: rtl/ps2tx_pkg.sv
package ps2tx_pkg;

    localparam int DATA_W    = 8;
    localparam int FRAME_LEN = DATA_W + 3;          // falls per frame incl. ack
    localparam int CNT_W     = $clog2(FRAME_LEN);
    localparam int LAST_SHIFT = FRAME_LEN - 1;       // fall count that ends frame

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_TX   = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_TXM_BIT = 1;
    localparam int STAT_IDLE_BIT = 0;
    localparam int STAT_TMO_BIT  = 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INHIBIT,
        ST_RTS,
        ST_SHIFT
    } tx_state_e;

    typedef struct packed {
        tx_state_e        st;
        logic             idle;
        logic             tmo;
        logic             en;
        logic             txm;
        logic             irq;
        logic             clk_oe;
        logic             dat_oe;
        logic [CNT_W-1:0] cnt;
    } tx_regs_t;

    localparam tx_regs_t TX_RST = '{st: ST_IDLE, idle: 1'b1, tmo: 1'b0,
                                    en: 1'b0, txm: 1'b0, irq: 1'b0,
                                    clk_oe: 1'b0, dat_oe: 1'b0, cnt: '0};

endpackage

// File: rtl/ps2tx_edge.sv
module ps2tx_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic fall
);
    logic [STAGES:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-1:0], line_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    assign fall = pipe_q[STAGES] & ~pipe_q[STAGES-1];

endmodule

// File: rtl/ps2tx_timer.sv
module ps2tx_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)             cnt_d = load_val;
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    AST_TIMER_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && zero) |=> zero);  // R5

endmodule

// File: rtl/ps2tx_frame.sv
module ps2tx_frame #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] data,
    input  logic          shift,
    output logic          bit_out
);
    localparam int SW = DW + 2;

    logic [SW-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load)       sr_d = {1'b1, ~^data, data};
        else if (shift) sr_d = {1'b1, sr_q[SW-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '1;
        else        sr_q <= sr_d;
    end

    assign bit_out = sr_q[0];

    AST_FRAME_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift) |=> $stable(sr_q));  // R10

endmodule

// File: rtl/ps2_host_tx.sv
module ps2_host_tx
    import ps2tx_pkg::*;
#(
    parameter int INHIBIT_CYC   = 20000,
    parameter int START_TMO_CYC = 3000000,
    parameter int FRAME_TMO_CYC = 400000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       kbd_clk_in,
    output logic       kbd_clk_oe,
    output logic       kbd_dat_oe,
    output logic       irq
);
    localparam int MAX_CYC = (START_TMO_CYC > FRAME_TMO_CYC)
                           ? ((START_TMO_CYC > INHIBIT_CYC) ? START_TMO_CYC : INHIBIT_CYC)
                           : ((FRAME_TMO_CYC > INHIBIT_CYC) ? FRAME_TMO_CYC : INHIBIT_CYC);
    localparam int TW = $clog2(MAX_CYC + 1);
    localparam logic [TW-1:0] INH_V   = TW'(INHIBIT_CYC);
    localparam logic [TW-1:0] START_V = TW'(START_TMO_CYC);
    localparam logic [TW-1:0] FRAME_V = TW'(FRAME_TMO_CYC);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(LAST_SHIFT);

    tx_regs_t q, n;

    logic          fall;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic          sh_load, sh_shift, sh_bit;
    logic          ctrl_wr, tx_wr, stat_wr;

    ps2tx_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .line_in(kbd_clk_in), .fall(fall));

    ps2tx_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .zero(tmr_zero));

    ps2tx_frame #(.DW(DATA_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .load(sh_load), .data(wr_data),
        .shift(sh_shift), .bit_out(sh_bit));

    always_comb begin
        ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
        tx_wr   = wr_en && (wr_addr == ADDR_TX);
        stat_wr = wr_en && (wr_addr == ADDR_STAT);
    end

    always_comb begin
        n        = q;
        n.irq    = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;

        if (stat_wr && wr_data[STAT_TMO_BIT]) n.tmo = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                if (tx_wr && q.en && q.txm) begin
                    n.st     = ST_INHIBIT;
                    n.idle   = 1'b0;
                    n.clk_oe = 1'b1;
                    n.dat_oe = 1'b0;
                    sh_load  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = INH_V;
                end
            end
            ST_INHIBIT: begin
                if (tmr_zero) begin
                    n.st     = ST_RTS;
                    n.clk_oe = 1'b0;
                    n.dat_oe = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = START_V;
                end
            end
            ST_RTS: begin
                if (fall) begin
                    n.st     = ST_SHIFT;
                    n.dat_oe = ~sh_bit;
                    n.cnt    = CNT_W'(1);
                    sh_shift = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = FRAME_V;
                end else if (tmr_zero) begin
                    n.st     = ST_IDLE;
                    n.idle   = 1'b1;
                    n.tmo    = 1'b1;
                    n.dat_oe = 1'b0;
                end
            end
            ST_SHIFT: begin
                if (fall) begin
                    if (q.cnt == LAST_C) begin
                        n.st     = ST_IDLE;
                        n.idle   = 1'b1;
                        n.dat_oe = 1'b0;
                        n.cnt    = '0;
                    end else begin
                        n.dat_oe = ~sh_bit;
                        n.cnt    = q.cnt + 1'b1;
                        sh_shift = 1'b1;
                    end
                end else if (tmr_zero) begin
                    n.st     = ST_IDLE;
                    n.idle   = 1'b1;
                    n.tmo    = 1'b1;
                    n.dat_oe = 1'b0;
                    n.cnt    = '0;
                end
            end
            default: n = TX_RST;
        endcase

        if (ctrl_wr) begin
            n.en  = wr_data[CTRL_EN_BIT];
            n.txm = wr_data[CTRL_TXM_BIT];
            if (!wr_data[CTRL_EN_BIT] || !wr_data[CTRL_TXM_BIT]) begin
                n.st     = ST_IDLE;
                n.idle   = 1'b1;
                n.clk_oe = 1'b0;
                n.dat_oe = 1'b0;
                n.cnt    = '0;
            end
        end

        if (n.idle && !q.idle) n.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= TX_RST;
        else        q <= n;
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_CTRL: begin
                rd_data[CTRL_EN_BIT]  = q.en;
                rd_data[CTRL_TXM_BIT] = q.txm;
            end
            ADDR_STAT: begin
                rd_data[STAT_IDLE_BIT] = q.idle;
                rd_data[STAT_TMO_BIT]  = q.tmo;
            end
            default: rd_data = '0;
        endcase
    end

    assign kbd_clk_oe = q.clk_oe;
    assign kbd_dat_oe = q.dat_oe;
    assign irq        = q.irq;

    AST_WRITE_DROPS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && q.idle && q.en && q.txm) |=> !q.idle);  // R1
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= LAST_C);  // R3
    AST_IDLE_LINES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        q.idle |-> (!q.clk_oe && !q.dat_oe));  // R4
    AST_TMO_WITH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.tmo) |-> $rose(q.idle));  // R5
    AST_MODE_OFF_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wr_data[CTRL_TXM_BIT]) |=> q.idle);  // R7
    AST_EN_OFF_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wr_data[CTRL_EN_BIT]) |=> q.idle);  // R8
    AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        q.irq |-> (q.idle && $past(!q.idle)));  // R9
    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && !q.idle && !ctrl_wr) |=> !q.idle || $past(q.st) != ST_IDLE);  // R10

endmodule

// File: tb/sim_ps2_host_tx.sv
`timescale 1ns/1ps
module sim_ps2_host_tx;
    localparam int INH   = 20;
    localparam int S_TMO = 400;
    localparam int F_TMO = 600;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       kbd_clk_in, kbd_clk_oe, kbd_dat_oe, irq;
    logic       dev_low = 1'b0;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;

    always #2.5 clk = ~clk;

    assign kbd_clk_in = !(dev_low || kbd_clk_oe);

    ps2_host_tx #(.INHIBIT_CYC(INH), .START_TMO_CYC(S_TMO), .FRAME_TMO_CYC(F_TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .kbd_clk_in(kbd_clk_in), .kbd_clk_oe(kbd_clk_oe),
        .kbd_dat_oe(kbd_dat_oe), .irq(irq));

    always @(negedge clk) if (irq) irq_cnt++;

    // {expected odd parity, data byte}
    localparam logic [8:0] VEC [7] = '{
        {1'b1, 8'h00}, {1'b1, 8'hFF}, {1'b1, 8'hA5}, {1'b0, 8'h01},
        {1'b0, 8'h80}, {1'b1, 8'h7E}, {1'b0, 8'hF4}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic wait_rts(output int n);
        n = 0;
        while (!(kbd_clk_oe == 1'b0 && kbd_dat_oe == 1'b1) && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic dev_falls(input int nf, output logic [9:0] bits);
        bits = '0;
        for (int k = 0; k < nf; k++) begin
            @(negedge clk); dev_low = 1'b1;
            repeat (5) @(negedge clk);
            if (k < 10) bits[k] = ~kbd_dat_oe;
            repeat (5) @(negedge clk);
            dev_low = 1'b0;
            repeat (10) @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all-requirements act=hung exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic [9:0] bits;
        int n, base;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(2'd2, r);
        chk("reset status R1", {24'd0, r}, 32'h1);
        chk("reset lines R4", {kbd_clk_oe, kbd_dat_oe, irq}, 0);

        // R10: disabled channel ignores transmit write
        wr(2'd1, 8'h55);
        repeat (4) @(negedge clk);
        rd(2'd2, r);
        chk("R10 write while disabled", {r[0], kbd_clk_oe}, 2'b10);
        wr(2'd0, 8'h01);             // enable only, mode off
        wr(2'd1, 8'h55);
        repeat (4) @(negedge clk);
        rd(2'd2, r);
        chk("R10 write with mode off", {r[0], kbd_clk_oe}, 2'b10);

        wr(2'd0, 8'h03);
        rd(2'd0, r);
        chk("control readback", {24'd0, r}, 32'h3);

        // vector table: complete frames
        for (int v = 0; v < 7; v++) begin
            base = irq_cnt;
            wr(2'd1, VEC[v][7:0]);
            rd(2'd2, r);
            chk("R1 idle cleared", {31'd0, r[0]}, 0);
            chk("R2 inhibit lines", {kbd_clk_oe, kbd_dat_oe}, 2'b10);
            wait_rts(n);
            chk("R2 inhibit length", {31'd0, n >= INH}, 1);
            dev_falls(11, bits);
            chk("R3 frame bits", {22'd0, bits}, {22'd0, 1'b1, VEC[v][8], VEC[v][7:0]});
            rd(2'd2, r);
            chk("R4 idle after 11th fall", {29'd0, r[0], kbd_clk_oe, kbd_dat_oe}, 3'b100);
            chk("R9 one irq per frame", irq_cnt - base, 1);
        end

        // R10: write during a busy transfer does not change the byte
        wr(2'd1, 8'hA5);
        wr(2'd1, 8'h00);
        wait_rts(n);
        dev_falls(11, bits);
        chk("R10 busy write ignored", {22'd0, bits}, {22'd0, 10'b1110100101});

        // R5: start timeout
        base = irq_cnt;
        wr(2'd1, 8'h3C);
        wait_rts(n);
        repeat (S_TMO - 20) @(negedge clk);
        rd(2'd2, r);
        chk("R5 still busy before limit", {30'd0, r[1:0]}, 0);
        repeat (40) @(negedge clk);
        rd(2'd2, r);
        chk("R5 start timeout status", {30'd0, r[1:0]}, 3);
        chk("R5 lines released", {kbd_clk_oe, kbd_dat_oe}, 0);
        chk("R9 irq on timeout", irq_cnt - base, 1);
        wr(2'd2, 8'h02);
        rd(2'd2, r);
        chk("R11 timeout flag cleared", {30'd0, r[1:0]}, 1);

        // R6: frame timeout after 3 falls
        wr(2'd1, 8'hC3);
        wait_rts(n);
        dev_falls(3, bits);
        repeat (340) @(negedge clk);
        rd(2'd2, r);
        chk("R6 still busy before limit", {30'd0, r[1:0]}, 0);
        repeat (250) @(negedge clk);
        rd(2'd2, r);
        chk("R6 frame timeout status", {30'd0, r[1:0]}, 3);
        wr(2'd2, 8'h02);

        // R7: mode bit cleared mid-frame
        base = irq_cnt;
        wr(2'd1, 8'h81);
        wait_rts(n);
        dev_falls(2, bits);
        wr(2'd0, 8'h01);
        rd(2'd2, r);
        chk("R7 mode-off ends transfer", {29'd0, r[0], kbd_clk_oe, kbd_dat_oe}, 3'b100);
        chk("R9 irq on mode abort", irq_cnt - base, 1);
        wr(2'd0, 8'h03);

        // R8: enable cleared during inhibit
        base = irq_cnt;
        wr(2'd1, 8'h18);
        repeat (3) @(negedge clk);
        wr(2'd0, 8'h02);
        rd(2'd2, r);
        chk("R8 disable aborts", {29'd0, r[0], kbd_clk_oe, kbd_dat_oe}, 3'b100);
        chk("R8 no timeout flag", {31'd0, r[1]}, 0);
        repeat (5) @(negedge clk);
        chk("R9 single irq on abort", irq_cnt - base, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule